// File: doc/BRIEF.md
# Direct Page Address Formation Unit

This block builds the wide global address for operand accesses that use the direct (zero-page) addressing mode. It holds two small registers on a simple register bus.

- **Direct page register.** It supplies the middle byte of the address. Outside special modes it can be written once only; a reset clears that lock.
- **Global page register.** It supplies the top bits of the address when the access comes from a global instruction.

For every other direct-mode access, the top bits come from an expansion input that the surrounding address logic drives. The short operand from the CPU always forms the lowest byte.

The register bus has these signals: an address, write data, a write strobe, combinational read data, and a special-mode input that lifts the write-once rule. The address output is a purely combinational function of the register contents and the access inputs. A register write becomes visible on both the read data and the address output from the clock edge that takes it.

Top module: `dpaf_top`

## Requirements
- R1: After reset the direct page and the global page both read 0x00, and the write lock on the direct page is clear.
- R2: The direct page register is read at register offset 0x11 at any time, in any mode.
- R3: With the special-mode input high, every write to offset 0x11 is accepted, and such writes do not arm the write lock.
- R4: With the special-mode input low, the first write to offset 0x11 after reset is accepted and arms the lock. Every later normal-mode write to that offset is ignored until the next reset.
- R5: The address output bits [15:8] equal the direct page register, and bits [7:0] equal the access operand.
- R6: When the global-instruction flag is high, address bits [22:16] equal the global page register. For example, direct page 0x80, global page 0x14 and operand 0x00 give 0x148000.
- R7: When the global-instruction flag is low, address bits [22:16] equal the expansion input.
- R8: The global page register sits at offset 0x10 and accepts every write in any mode, storing write-data bits [6:0]. Its read returns those 7 bits, with bit 7 reading 0.
- R9: Reads at any offset other than 0x10 and 0x11 return 0x00. Writes to such offsets change neither register.
- R10: A register write does not change the read data or the address output before the clock edge that takes it, and does change them right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register bus offset |
| reg_wdata | input | 8 | Register bus write data |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| special_mode | input | 1 | High in special modes; lifts the write-once rule |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| acc_operand | input | 8 | Direct-mode operand byte from the CPU |
| acc_global | input | 1 | High when the access comes from a global instruction |
| ext_upper | input | 7 | Upper address bits from local-to-global expansion |
| gaddr | output | 23 | Formed global address |

## Verification
The bench builds the block with its default parameters: 8-bit direct page, 7-bit global page, 8-bit operand, and offsets 0x10 and 0x11 on an 8-bit register bus. With these values every address bit is reachable, including the all-ones corner 0x7FFFFF and the example address 0x148000. They also let the bench drive a written value of 0xFF into the global page, to show that bit 7 is dropped. The bench walks the lock through these orders:
- special writes before the first normal write;
- repeated normal writes;
- a reset that re-opens the lock.

Two unmapped offsets placed next to the mapped ones show that decoding is exact.

// File: rtl/dpaf_pkg.sv
// Package: shared constants and the register-select type for the direct page
// address formation unit. Assumes an 8-bit register bus by default.
package dpaf_pkg;

    // Default register offsets on the register bus
    localparam logic [7:0] DEF_DP_OFFSET = 8'h11;
    localparam logic [7:0] DEF_GP_OFFSET = 8'h10;

    // Decoded target of a register bus cycle
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DP   = 2'd1,
        SEL_GP   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/dpaf_page_reg.sv
// Module: one page register with synchronous active-low reset to zero.
// With ONCE = 1 it accepts every write while special is high, and only the
// first write while special is low; that first normal write arms a lock that
// only reset clears. With ONCE = 0 it accepts every write.
// Assumes wr_en is already qualified by the address decode.
module dpaf_page_reg #(
    parameter int W    = 8,
    parameter bit ONCE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         special,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    generate
        if (ONCE) begin : g_once
            logic locked_r;
            logic accept;

            // Decide whether this write may land in the register
            always_comb begin
                accept = wr_en && (special || !locked_r);
            end

            // Hold the page value
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= '0;
                end else if (accept) begin
                    q_r <= wdata;
                end
            end

            // Arm the lock on the first accepted normal-mode write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    locked_r <= 1'b0;
                end else if (wr_en && !special) begin
                    locked_r <= 1'b1;
                end
            end
        end else begin : g_free
            logic unused_special;

            // Special mode has no effect on a free register
            always_comb begin
                unused_special = special;
            end

            // Hold the page value
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_r <= '0;
                end else if (wr_en) begin
                    q_r <= wdata;
                end
            end
        end
    endgenerate

    assign q = q_r;

endmodule

// File: rtl/dpaf_read_mux.sv
// Module: combinational read-back of the page registers. Narrow registers are
// zero-extended to the bus width; unmapped offsets read zero.
// Assumes DP_W and GP_W do not exceed DATA_W.
module dpaf_read_mux #(
    parameter int DATA_W = 8,
    parameter int DP_W   = 8,
    parameter int GP_W   = 7
) (
    input  dpaf_pkg::reg_sel_e sel,
    input  logic [DP_W-1:0]    dp_q,
    input  logic [GP_W-1:0]    gp_q,
    output logic [DATA_W-1:0]  rdata
);

    // Select and zero-extend the addressed register
    always_comb begin
        rdata = '0;
        unique case (sel)
            dpaf_pkg::SEL_DP: rdata[DP_W-1:0] = dp_q;
            dpaf_pkg::SEL_GP: rdata[GP_W-1:0] = gp_q;
            default:          rdata = '0;
        endcase
    end

endmodule

// File: rtl/dpaf_addr_former.sv
// Module: combinational global address formation for direct-mode accesses.
// The layout from the top down is {upper page, direct page, operand}. The
// upper page comes from the global page register for global instructions and
// from the expansion input otherwise.
module dpaf_addr_former #(
    parameter int DP_W  = 8,
    parameter int GP_W  = 7,
    parameter int OP_W  = 8,
    localparam int GA_W = GP_W + DP_W + OP_W
) (
    input  logic [DP_W-1:0] dp_q,
    input  logic [GP_W-1:0] gp_q,
    input  logic [OP_W-1:0] operand,
    input  logic            is_global,
    input  logic [GP_W-1:0] ext_upper,
    output logic [GA_W-1:0] gaddr
);

    logic [GP_W-1:0] upper;

    // Pick the source of the upper address bits
    always_comb begin
        upper = is_global ? gp_q : ext_upper;
    end

    // Concatenate the address fields
    always_comb begin
        gaddr = {upper, dp_q, operand};
    end

endmodule

// File: rtl/dpaf_top.sv
// Module: top of the direct page address formation unit. Decodes the register
// bus, holds a write-once direct page register and a free global page
// register, and forms the global address for direct-mode accesses.
// Assumes at most one register write per cycle and a synchronous active-low
// reset.
module dpaf_top #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          DP_W      = 8,
    parameter int          GP_W      = 7,
    parameter int          OP_W      = 8,
    parameter logic [7:0]  DP_OFFSET = dpaf_pkg::DEF_DP_OFFSET,
    parameter logic [7:0]  GP_OFFSET = dpaf_pkg::DEF_GP_OFFSET,
    localparam int         GA_W      = GP_W + DP_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              special_mode,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [OP_W-1:0]   acc_operand,
    input  logic              acc_global,
    input  logic [GP_W-1:0]   ext_upper,
    output logic [GA_W-1:0]   gaddr
);

    dpaf_pkg::reg_sel_e sel;
    logic [DP_W-1:0]    dp_q;
    logic [GP_W-1:0]    gp_q;
    logic               dp_wr;
    logic               gp_wr;

    // Decode the register bus offset
    always_comb begin
        if (reg_addr == ADDR_W'(DP_OFFSET)) begin
            sel = dpaf_pkg::SEL_DP;
        end else if (reg_addr == ADDR_W'(GP_OFFSET)) begin
            sel = dpaf_pkg::SEL_GP;
        end else begin
            sel = dpaf_pkg::SEL_NONE;
        end
    end

    // Qualify the write strobe per register
    always_comb begin
        dp_wr = reg_wr && (sel == dpaf_pkg::SEL_DP);
        gp_wr = reg_wr && (sel == dpaf_pkg::SEL_GP);
    end

    dpaf_page_reg #(.W(DP_W), .ONCE(1'b1)) u_dp_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dp_wr),
        .special (special_mode),
        .wdata   (reg_wdata[DP_W-1:0]),
        .q       (dp_q)
    );

    dpaf_page_reg #(.W(GP_W), .ONCE(1'b0)) u_gp_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gp_wr),
        .special (special_mode),
        .wdata   (reg_wdata[GP_W-1:0]),
        .q       (gp_q)
    );

    dpaf_read_mux #(.DATA_W(DATA_W), .DP_W(DP_W), .GP_W(GP_W)) u_rd_mux (
        .sel   (sel),
        .dp_q  (dp_q),
        .gp_q  (gp_q),
        .rdata (reg_rdata)
    );

    dpaf_addr_former #(.DP_W(DP_W), .GP_W(GP_W), .OP_W(OP_W)) u_addr (
        .dp_q      (dp_q),
        .gp_q      (gp_q),
        .operand   (acc_operand),
        .is_global (acc_global),
        .ext_upper (ext_upper),
        .gaddr     (gaddr)
    );

endmodule

// File: rtl/dpaf_checker.sv
// Module: property checker for dpaf_top, attached by the bind below. It keeps
// its own copy of the write lock, built from the bus ports only.
module dpaf_checker #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          DP_W      = 8,
    parameter int          GP_W      = 7,
    parameter int          OP_W      = 8,
    parameter logic [7:0]  DP_OFFSET = 8'h11,
    parameter logic [7:0]  GP_OFFSET = 8'h10,
    localparam int         GA_W      = GP_W + DP_W + OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              special_mode,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [OP_W-1:0]   acc_operand,
    input logic              acc_global,
    input logic [GP_W-1:0]   ext_upper,
    input logic [GA_W-1:0]   gaddr,
    input logic [DP_W-1:0]   dp_q,
    input logic [GP_W-1:0]   gp_q
);

    logic lock_m;
    logic hit_dp;
    logic hit_gp;

    // Decode the offsets independently of the design
    always_comb begin
        hit_dp = (reg_addr == ADDR_W'(DP_OFFSET));
        hit_gp = (reg_addr == ADDR_W'(GP_OFFSET));
    end

    // Shadow lock: set by any normal-mode write to the direct page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_m <= 1'b0;
        end else if (reg_wr && hit_dp && !special_mode) begin
            lock_m <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (dp_q == '0 && gp_q == '0)); // R1

    AST_SPECIAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_dp && special_mode) |=> dp_q == $past(reg_wdata[DP_W-1:0])); // R3

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_dp && !special_mode && lock_m) |=> $stable(dp_q)); // R4

    AST_LOW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        gaddr[DP_W+OP_W-1:0] == {dp_q, acc_operand}); // R5

    AST_GLOBAL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        acc_global |-> gaddr[GA_W-1:DP_W+OP_W] == gp_q); // R6

    AST_EXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_global |-> gaddr[GA_W-1:DP_W+OP_W] == ext_upper); // R7

    AST_GP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_gp |-> reg_rdata[DATA_W-1:GP_W] == '0); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_gp && !hit_dp) |-> reg_rdata == '0); // R9

endmodule

bind dpaf_top dpaf_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DP_W(DP_W), .GP_W(GP_W), .OP_W(OP_W),
    .DP_OFFSET(DP_OFFSET), .GP_OFFSET(GP_OFFSET)
) u_dpaf_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .special_mode(special_mode), .reg_rdata(reg_rdata),
    .acc_operand(acc_operand), .acc_global(acc_global), .ext_upper(ext_upper),
    .gaddr(gaddr), .dp_q(dp_q), .gp_q(gp_q)
);

// File: tb/dpaf_top_tb_top.sv
// Bench for dpaf_top: a vector table for address formation, then directed
// tests for reset, the write lock, read-back and unmapped offsets.
module dpaf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic        reg_wr = 1'b0;
    logic        special_mode = 1'b0;
    logic [7:0]  reg_rdata;
    logic [7:0]  acc_operand = 8'h00;
    logic        acc_global = 1'b0;
    logic [6:0]  ext_upper = 7'h00;
    logic [22:0] gaddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpaf_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .special_mode(special_mode), .reg_rdata(reg_rdata),
        .acc_operand(acc_operand), .acc_global(acc_global),
        .ext_upper(ext_upper), .gaddr(gaddr)
    );

    // Address-formation vectors: direct page, global page, operand, flag, expansion, expected
    localparam int NV = 6;
    localparam logic [7:0]  V_DP   [NV] = '{8'h80, 8'h12, 8'h12, 8'hFF, 8'h00, 8'hC3};
    localparam logic [6:0]  V_GP   [NV] = '{7'h14, 7'h7F, 7'h7F, 7'h00, 7'h2A, 7'h01};
    localparam logic [7:0]  V_OP   [NV] = '{8'h00, 8'h34, 8'h34, 8'hFF, 8'hA5, 8'h3C};
    localparam logic        V_GL   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [6:0]  V_EXT  [NV] = '{7'h00, 7'h05, 7'h05, 7'h7F, 7'h11, 7'h00};
    localparam logic [22:0] V_EXP  [NV] = '{23'h148000, 23'h7F1234, 23'h051234,
                                            23'h7FFFFF, 23'h2A00A5, 23'h00C33C};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input logic spec);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; special_mode = spec; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; special_mode = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        do_reset();

        // R1: reset values
        reg_read(8'h11, rd); check("R1 dp after reset", rd, 8'h00);
        reg_read(8'h10, rd); check("R1 gp after reset", rd, 8'h00);

        // R5 R6 R7 R3: vector table, direct page written in special mode
        for (int i = 0; i < NV; i++) begin
            reg_write(8'h11, V_DP[i], 1'b1);
            reg_write(8'h10, {1'b0, V_GP[i]}, 1'b0);
            @(negedge clk);
            acc_operand = V_OP[i]; acc_global = V_GL[i]; ext_upper = V_EXT[i];
            #1;
            check("R5/R6/R7 vector gaddr", gaddr, V_EXP[i]);
        end

        // R4: first normal write lands, later ones are ignored
        do_reset();
        reg_write(8'h11, 8'h55, 1'b0);
        reg_read(8'h11, rd); check("R4 first normal write", rd, 8'h55);
        reg_write(8'h11, 8'hAA, 1'b0);
        reg_read(8'h11, rd); check("R4 second normal write ignored", rd, 8'h55);
        @(negedge clk); acc_global = 1'b0; acc_operand = 8'h01; ext_upper = 7'h02; #1;
        check("R4 gaddr keeps locked page", gaddr, 23'h025501);
        // R3: special write still lands after lock
        reg_write(8'h11, 8'hAA, 1'b1);
        reg_read(8'h11, rd); check("R3 special write after lock", rd, 8'hAA);

        // R3: special writes do not arm the lock
        do_reset();
        reg_write(8'h11, 8'h11, 1'b1);
        reg_write(8'h11, 8'h22, 1'b0);
        reg_read(8'h11, rd); check("R3 lock not armed by special write", rd, 8'h22);
        reg_write(8'h11, 8'h33, 1'b0);
        reg_read(8'h11, rd); check("R4 lock armed by normal write", rd, 8'h22);

        // R2: read in special mode as well
        @(negedge clk); special_mode = 1'b1; reg_addr = 8'h11; #1;
        check("R2 read in special mode", reg_rdata, 8'h22);
        special_mode = 1'b0;

        // R1: reset re-opens the lock
        do_reset();
        reg_read(8'h11, rd); check("R1 dp cleared by reset", rd, 8'h00);
        reg_write(8'h11, 8'h77, 1'b0);
        reg_read(8'h11, rd); check("R1 lock cleared by reset", rd, 8'h77);

        // R8: global page keeps 7 bits, writable repeatedly in normal mode
        reg_write(8'h10, 8'hFF, 1'b0);
        reg_read(8'h10, rd); check("R8 gp bit7 reads zero", rd, 8'h7F);
        reg_write(8'h10, 8'h81, 1'b0);
        reg_read(8'h10, rd); check("R8 gp rewrite", rd, 8'h01);

        // R9: unmapped offsets
        reg_write(8'h12, 8'hFF, 1'b1);
        reg_write(8'h0F, 8'hFF, 1'b0);
        reg_read(8'h12, rd); check("R9 unmapped read 0x12", rd, 8'h00);
        reg_read(8'h00, rd); check("R9 unmapped read 0x00", rd, 8'h00);
        reg_read(8'h11, rd); check("R9 dp unchanged", rd, 8'h77);
        reg_read(8'h10, rd); check("R9 gp unchanged", rd, 8'h01);

        // R10: write visible only after the taking edge
        @(negedge clk);
        reg_addr = 8'h10; reg_wdata = 8'h3C; reg_wr = 1'b1;
        acc_global = 1'b1; acc_operand = 8'h00;
        #1;
        check("R10 rdata before edge", reg_rdata, 8'h01);
        check("R10 gaddr before edge", gaddr, 23'h017700);
        @(posedge clk); #1;
        reg_wr = 1'b0;
        check("R10 rdata after edge", reg_rdata, 8'h3C);
        check("R10 gaddr after edge", gaddr, 23'h3C7700);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule